// File: doc/BRIEF.md
# Packed Element Rotate Unit

This unit carries out the vector rotate operations of a vector execution pipeline. It takes one 32-bit vector instruction word and a 64-bit packed source. The rotate amount comes from one of three places: a second 64-bit packed source, a scalar value, or an immediate carried in the instruction. The unit rotates every element of the packed source left or right. The element width is 8, 16, 32 or 64 bits and is set by a separate select input.

The unit has one datapath, which only rotates left. A rotate to the right is done by negating the masked amount before it reaches that datapath. When mask-enable is off, elements whose mask bit is clear keep the value given on an old-destination input. Encodings that are not rotates raise an illegal flag, and the result register is left alone. Every accepted request gives one registered response in the next cycle, marked by `out_valid`.

Top module: `pkd_rot_unit`

## Requirements
- R1: An instruction is a rotate when all of these hold: bits 6:0 are 1010111, and bits 14:12 are 000 (per-element amounts) or 100 (scalar amount), and bits 31:26 are 010101 (rotate left) or 010100 (rotate right).
- R2: When bits 14:12 are 011 and bits 31:27 are 01010, the instruction is always a rotate right, whatever bit 26 holds. Its amount is the zero-extended 6-bit value {bit 26, bits 19:15}.
- R3: `sew_sel` picks the element width: 00 gives 8 bits, 01 gives 16, 10 gives 32 and 11 gives 64. Elements are packed little-endian, so element 0 sits in the least significant bits.
- R4: Before use, a rotate amount keeps only its low log2(width) bits. These are 3, 4, 5 or 6 bits for the four widths.
- R5: A rotate right by n gives the same result as a rotate left by (-n) mod width. A rotation keeps the number of set bits in each element.
- R6: In the per-element form, element i of `vec_a` is rotated by the low bits of element i of `vec_b`. In the scalar form, every element uses `scalar_in[5:0]`.
- R7: An amount that is zero after masking leaves the element unchanged.
- R8: Instruction bit 25 is mask-enable-off. When it is 0, element i is written only if `elem_mask[i]` is 1, and otherwise takes element i of `old_dest`. When it is 1, all elements are written.
- R9: Any other encoding sets `illegal` together with `out_valid`, and `result` keeps its previous value.
- R10: `out_valid` rises on the clock edge after a cycle with `in_valid` high, and `result` and `illegal` update on that same edge. With no request, `out_valid` and `illegal` are 0 in the next cycle.
- R11: After reset, `result`, `out_valid` and `illegal` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| instr | input | 32 | Vector instruction word |
| sew_sel | input | 2 | Element width select |
| vec_a | input | 64 | Packed elements to rotate |
| vec_b | input | 64 | Packed per-element amounts |
| scalar_in | input | 64 | Scalar amount source |
| elem_mask | input | 8 | Per-element write mask, bit i for element i |
| old_dest | input | 64 | Prior destination value for masked-off elements |
| out_valid | output | 1 | Response strobe |
| result | output | 64 | Rotated packed result |
| illegal | output | 1 | Non-rotate encoding flag |

## Verification
The assertions check the following on every cycle:
- The one-cycle response timing, and that `out_valid` drops when there is no request.
- That `illegal` is only ever seen with `out_valid`, and that `result` does not change on an illegal response.
- Inside each lane, that a rotation keeps the element's set-bit count, and that a zero effective amount passes the element through unchanged.

Only the bench scenarios can show the values themselves. These include:
- that direction and amount are decoded correctly, including the free bit 26 in the immediate form;
- that amounts are masked to the element width;
- that per-element amounts select the right element of `vec_b`;
- that masked-off elements keep the old-destination value.

// File: rtl/pkd_rot_pkg.sv
package pkd_rot_pkg;
  localparam logic [6:0] OPC_VEC   = 7'b1010111;
  localparam logic [5:0] F6_LEFT   = 6'b010101;
  localparam logic [5:0] F6_RIGHT  = 6'b010100;
  localparam logic [2:0] F3_VEC    = 3'b000;
  localparam logic [2:0] F3_SCALAR = 3'b100;
  localparam logic [2:0] F3_IMM    = 3'b011;

  typedef struct packed {
    logic       legal;
    logic       dir_right;
    logic       amt_per_elem;
    logic       amt_from_imm;
    logic       write_all;
    logic [5:0] imm_amt;
  } rot_dec_t;
endpackage

// File: rtl/pkd_rot_decode.sv
module pkd_rot_decode
  import pkd_rot_pkg::*;
(
  input  logic [31:0] instr,
  output rot_dec_t    dec
);
  logic [5:0] f6;
  logic [2:0] f3;
  logic       opc_hit, reg_form, imm_form, f6_left, f6_right;

  assign f6       = instr[31:26];
  assign f3       = instr[14:12];
  assign opc_hit  = (instr[6:0] == OPC_VEC);
  assign reg_form = (f3 == F3_VEC) || (f3 == F3_SCALAR);
  assign f6_left  = (f6 == F6_LEFT);
  assign f6_right = (f6 == F6_RIGHT);
  assign imm_form = (f3 == F3_IMM) && (f6[5:1] == F6_RIGHT[5:1]);

  always_comb begin
    dec.legal        = opc_hit && ((reg_form && (f6_left || f6_right)) || imm_form);
    dec.dir_right    = imm_form || f6_right;
    dec.amt_per_elem = (f3 == F3_VEC);
    dec.amt_from_imm = (f3 == F3_IMM);
    dec.write_all    = instr[25];
    dec.imm_amt      = {instr[26], instr[19:15]};
  end

  // R2: the immediate form can only ever rotate right
  always_comb begin
    if (dec.legal && dec.amt_from_imm) begin
      p_imm_right_r2: assert (dec.dir_right);
    end
  end
endmodule

// File: rtl/pkd_rot_lane.sv
module pkd_rot_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  input  logic [5:0]   amt_raw,
  input  logic         dir_right,
  output logic [W-1:0] dout
);
  localparam int SH = $clog2(W);

  function automatic logic [W-1:0] rotl(input logic [W-1:0] x, input logic [SH-1:0] n);
    logic [2*W-1:0] t;
    t = {x, x} << n;
    return t[2*W-1:W];
  endfunction

  logic [SH-1:0] amt_m;
  logic [SH-1:0] amt_eff;
  logic          unused_amt;

  assign amt_m      = amt_raw[SH-1:0];
  assign amt_eff    = dir_right ? (SH'(0) - amt_m) : amt_m;
  assign dout       = rotl(din, amt_eff);
  assign unused_amt = ^amt_raw;

  always_comb begin
    p_bits_kept_r5: assert ($countones(dout) == $countones(din));
    if (amt_eff == '0) begin
      p_zero_amt_r7: assert (dout == din);
    end
  end
endmodule

// File: rtl/pkd_rot_unit.sv
module pkd_rot_unit
  import pkd_rot_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int MIN_ELW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [1:0]        sew_sel,
  input  logic [DATA_W-1:0] vec_a,
  input  logic [DATA_W-1:0] vec_b,
  input  logic [DATA_W-1:0] scalar_in,
  input  logic [DATA_W/MIN_ELW-1:0] elem_mask,
  input  logic [DATA_W-1:0] old_dest,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);
  localparam int NUM_SEW = 4;
  localparam int MASK_W  = DATA_W / MIN_ELW;

  rot_dec_t dec;
  logic [5:0] shared_amt;
  logic [NUM_SEW-1:0][DATA_W-1:0] cand;
  logic [DATA_W-1:0] sel_val;
  logic unused_bits;

  pkd_rot_decode u_dec (.instr(instr), .dec(dec));

  assign shared_amt  = dec.amt_from_imm ? dec.imm_amt : scalar_in[5:0];
  assign unused_bits = ^{instr, scalar_in, vec_b};

  for (genvar g = 0; g < NUM_SEW; g++) begin : g_sew
    localparam int W = MIN_ELW << g;
    localparam int N = DATA_W / W;
    for (genvar e = 0; e < N; e++) begin : g_elem
      logic [W-1:0] rot_e;
      logic [5:0]   amt_e;
      assign amt_e = dec.amt_per_elem ? vec_b[e*W +: 6] : shared_amt;
      pkd_rot_lane #(.W(W)) u_lane (
        .din      (vec_a[e*W +: W]),
        .amt_raw  (amt_e),
        .dir_right(dec.dir_right),
        .dout     (rot_e)
      );
      assign cand[g][e*W +: W] = (dec.write_all || elem_mask[e]) ? rot_e : old_dest[e*W +: W];
    end
    if (N < MASK_W) begin : g_unused_mask
      logic unused_mask;
      assign unused_mask = ^elem_mask[MASK_W-1:N];
    end
  end

  assign sel_val = cand[sew_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      illegal   <= in_valid && !dec.legal;
      if (in_valid && dec.legal) result <= sel_val;
    end
  end

  p_valid_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !illegal);
  p_illegal_vld_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> out_valid);
  p_illegal_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dec.legal) |=> $stable(result));
endmodule

// File: tb/pkd_rot_unit_tb_top.sv
module pkd_rot_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [1:0]  sew_sel = '0;
  logic [63:0] vec_a = '0, vec_b = '0, scalar_in = '0, old_dest = '0;
  logic [7:0]  elem_mask = '0;
  logic        out_valid, illegal;
  logic [63:0] result;

  int n_chk = 0;
  int n_err = 0;
  logic [63:0] exp_res = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkd_rot_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .sew_sel(sew_sel), .vec_a(vec_a), .vec_b(vec_b), .scalar_in(scalar_in),
    .elem_mask(elem_mask), .old_dest(old_dest), .out_valid(out_valid),
    .result(result), .illegal(illegal)
  );

  function automatic logic [31:0] enc(logic [5:0] f6, logic vm, logic [4:0] r1,
                                      logic [2:0] f3, logic [6:0] opc);
    return {f6, vm, 5'd9, r1, f3, 5'd3, opc};
  endfunction

  function automatic logic ref_legal(logic [31:0] w);
    if (w[6:0] != 7'b1010111) return 1'b0;
    if (w[14:12] == 3'b011) return (w[31:27] == 5'b01010);
    if (w[14:12] == 3'b000 || w[14:12] == 3'b100)
      return (w[31:26] == 6'b010101) || (w[31:26] == 6'b010100);
    return 1'b0;
  endfunction

  // bit-index model: left takes bit (j-k), right takes bit (j+k)
  function automatic logic [63:0] ref_res(logic [31:0] w, logic [1:0] sw, logic [63:0] a,
                                          logic [63:0] b, logic [63:0] s, logic [7:0] m,
                                          logic [63:0] od);
    logic [63:0] r;
    int wd, ne, k, raw;
    logic right;
    wd = 8 << sw;
    ne = 64 / wd;
    right = (w[14:12] == 3'b011) || (w[31:26] == 6'b010100);
    r = od;
    for (int e = 0; e < ne; e++) begin
      if (w[14:12] == 3'b000) raw = int'((b >> (e*wd)) & 64'h3f);
      else if (w[14:12] == 3'b011) raw = int'({w[26], w[19:15]});
      else raw = int'(s[5:0]);
      k = raw % wd;
      if (w[25] || m[e]) begin
        for (int j = 0; j < wd; j++) begin
          if (right) r[e*wd+j] = a[e*wd + ((j + k) % wd)];
          else       r[e*wd+j] = a[e*wd + ((j - k + wd) % wd)];
        end
      end
    end
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic issue(string req, logic [31:0] w, logic [1:0] sw, logic [63:0] a,
                       logic [63:0] b, logic [63:0] s, logic [7:0] m, logic [63:0] od);
    logic lg;
    @(negedge clk);
    instr = w; sew_sel = sw; vec_a = a; vec_b = b; scalar_in = s;
    elem_mask = m; old_dest = od; in_valid = 1'b1;
    lg = ref_legal(w);
    if (lg) exp_res = ref_res(w, sw, a, b, s, m, od);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R10 valid"}, {63'd0, out_valid}, 64'd1);
    check({req, " R9 flag"}, {63'd0, illegal}, {63'd0, !lg});
    check({req, " result"}, result, exp_res);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 result", result, 64'd0);
    check("R11 valid", {63'd0, out_valid}, 64'd0);
    check("R11 illegal", {63'd0, illegal}, 64'd0);
    rst_n = 1'b1;

    // R1 R6 per-element rotate left, 8-bit
    issue("R1 R6 vv rol", enc(6'b010101, 1'b1, 5'd0, 3'b000, 7'b1010111), 2'd0,
          64'h8040201008040201, 64'h0706050403020100, 64'd0, 8'h00, 64'd0);
    // R3 little-endian placement, 16-bit rotate left by 1
    issue("R3 vx rol16", enc(6'b010101, 1'b1, 5'd0, 3'b100, 7'b1010111), 2'd1,
          64'h0000_0000_8000_0001, 64'd0, 64'd1, 8'h00, 64'd0);
    check("R3 explicit", result, 64'h0000_0000_0001_0002);
    // R5 rotate right by scalar
    issue("R5 vx ror16", enc(6'b010100, 1'b1, 5'd0, 3'b100, 7'b1010111), 2'd1,
          64'h1234_5678_9abc_def0, 64'd0, 64'd4, 8'h00, 64'd0);
    check("R5 explicit", result, 64'h4123_8567_c9ab_0def);
    // R2 immediate form, bit 26 set, amount 35 on 64-bit
    issue("R2 vi amt35", enc(6'b010101, 1'b1, 5'd3, 3'b011, 7'b1010111), 2'd3,
          64'h0000_0000_0000_0008, 64'd0, 64'd0, 8'h00, 64'd0);
    check("R2 explicit", result, 64'h0000_0001_0000_0000);
    issue("R2 vi bit26 clear", enc(6'b010100, 1'b1, 5'd1, 3'b011, 7'b1010111), 2'd2,
          64'h0000_0001_0000_0002, 64'd0, 64'd0, 8'h00, 64'd0);
    check("R2 explicit2", result, 64'h8000_0000_0000_0001);
    // R4 R7 amount 8 on 8-bit masks to zero
    issue("R4 R7 mask8", enc(6'b010100, 1'b1, 5'd0, 3'b100, 7'b1010111), 2'd0,
          64'hdead_beef_0123_4567, 64'd0, 64'd8, 8'h00, 64'd0);
    check("R7 unchanged", result, 64'hdead_beef_0123_4567);
    issue("R4 R7 amt64 on 64", enc(6'b010101, 1'b1, 5'd0, 3'b100, 7'b1010111), 2'd3,
          64'hfeed_face_cafe_f00d, 64'd0, 64'h40, 8'h00, 64'd0);
    check("R7 unchanged64", result, 64'hfeed_face_cafe_f00d);
    // R8 masked writes
    issue("R8 vm0 sew8", enc(6'b010101, 1'b0, 5'd0, 3'b100, 7'b1010111), 2'd0,
          64'h0101_0101_0101_0101, 64'd0, 64'd1, 8'h05, 64'haaaa_aaaa_aaaa_aaaa);
    check("R8 explicit", result, 64'haaaa_aaaa_aa02_aa02);
    issue("R8 vm0 sew32", enc(6'b010100, 1'b0, 5'd0, 3'b000, 7'b1010111), 2'd2,
          64'h0000_0010_0000_0010, 64'h0000_0004_0000_0004, 64'd0, 8'h02, 64'h5555_5555_5555_5555);
    check("R8 explicit32", result, 64'h0000_0001_5555_5555);
    // R9 illegal encodings keep result
    issue("R9 bad opcode", enc(6'b010101, 1'b1, 5'd0, 3'b000, 7'b1010011), 2'd0,
          64'h1, 64'd1, 64'd1, 8'h00, 64'd0);
    issue("R9 bad f6", enc(6'b010111, 1'b1, 5'd0, 3'b000, 7'b1010111), 2'd0,
          64'h1, 64'd1, 64'd1, 8'h00, 64'd0);
    issue("R9 bad f3", enc(6'b010100, 1'b1, 5'd0, 3'b001, 7'b1010111), 2'd0,
          64'h1, 64'd1, 64'd1, 8'h00, 64'd0);
    check("R9 held", result, 64'h0000_0001_5555_5555);
    // R10 idle cycle
    @(negedge clk);
    check("R10 idle valid", {63'd0, out_valid}, 64'd0);
    check("R10 idle illegal", {63'd0, illegal}, 64'd0);

    // constrained random mix: R1 R3 R6 R8
    for (int i = 0; i < 600; i++) begin
      logic [31:0] w;
      int kind;
      kind = int'($urandom % 8);
      case (kind)
        0, 1: w = enc(($urandom % 2) ? 6'b010101 : 6'b010100, 1'($urandom), 5'($urandom), 3'b000, 7'b1010111);
        2, 3: w = enc(($urandom % 2) ? 6'b010101 : 6'b010100, 1'($urandom), 5'($urandom), 3'b100, 7'b1010111);
        4, 5: w = enc({5'b01010, 1'($urandom)}, 1'($urandom), 5'($urandom), 3'b011, 7'b1010111);
        6:    w = $urandom;
        default: w = enc(6'($urandom), 1'($urandom), 5'($urandom), 3'($urandom), 7'b1010111);
      endcase
      issue("R1 R3 R6 R8 random", w, 2'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
            {$urandom, $urandom}, 8'($urandom), {$urandom, $urandom});
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule